// File: doc/BRIEF.md
# LCD Display Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, data enable and the zero-based pixel column and row inside the visible area. Two counters run on the pixel clock. The horizontal counter steps once per clock and wraps at the programmed line total. The vertical counter steps once per line and wraps at the programmed frame total. Each line and each frame is measured from the start of its sync pulse. Sync occupies the first counts. Active video begins after sync plus back porch. The front porch fills the remainder up to the total.

Software programs the block through a small word-addressed register port. It sets the sync widths, the active start and end, the totals and the output polarities. It then starts the raster with an enable bit. A disable request is honoured only at the end of the current frame. A status flag then reports that the generator has stopped. A second status flag marks each end of frame and can raise an interrupt.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset the generator is stopped, with counters at 0. With the configuration at 0, hsync, vsync, de and irq are 0, and status (address 7) reads 0.
- R2: While running, the horizontal count goes 0 to H_total-1 and wraps. The vertical count advances on each horizontal wrap and wraps after line V_total-1. Totals sit at address 3: H in bits [25:16], V in bits [9:0].
- R3: Raw hsync is active while the horizontal count is below the hsync end (address 1, bits [9:0]). Raw vsync is active while the vertical count is below the vsync end (address 2, bits [9:0]).
- R4: Raw de is active only when the horizontal count lies in [start, end) from address 4 and the vertical count lies in [start, end) from address 5. In both registers start is in bits [25:16] and end in bits [9:0]. pix_x and pix_y give the counts minus the starts while de is active, and are 0 otherwise.
- R5: At address 0, bit 11 inverts hsync, bit 8 inverts vsync and bit 9 inverts de. Bit 10 makes pix_clk_o the inverted clock, so data launched on the rising clock edge reaches the panel on a falling pixel-clock edge. When stopped, every control output sits at its inactive level.
- R6: Writing address 6 with bit 3 set and bit 4 clear, while stopped, starts the raster at count 0,0 on the next cycle. Writing bit 4 while running stops it after the last pixel of the current frame. At that point status bit 0 is set and the counters are held at 0.
- R7: Status bit 5 is set after the last pixel of every frame. Writing 0 to that bit at address 7 clears it. Status bit 0 is also cleared by writing 0.
- R8: irq is high exactly when status bit 5 is set and control bit 13 (address 6) is set.
- R9: Timing fields and configuration bits read back as written at their stated positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word address for read and write |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr, combinational |
| hsync | output | 1 | Horizontal sync, polarity per config |
| vsync | output | 1 | Vertical sync, polarity per config |
| de | output | 1 | Data enable, polarity per config |
| pix_x | output | CW | Active-area column |
| pix_y | output | CW | Active-area row |
| pix_clk_o | output | 1 | Panel pixel clock, optionally inverted |
| irq | output | 1 | End-of-frame interrupt |

## Verification
The assertions assume that the line and frame totals are at least 2 and are not rewritten while the raster runs. They also assume that the active and sync windows fit inside the totals. The stimulus writes every timing register only while the generator is stopped. It uses a 12-by-6 raster whose windows all lie inside those totals. Disable requests are issued well inside a frame, so no stop coincides with a configuration write.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rd_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic          pix_clk_o,
  output logic          irq
);
  localparam int HI = 16;

  logic [3:0]    cfg;
  logic [2:0]    ctl;
  logic [CW-1:0] hs_end, vs_end, h_tot, v_tot, h_beg, h_fin, v_beg, v_fin;
  logic [CW-1:0] hcnt, vcnt;
  logic          running, st_dis, st_eof;

  wire w_cfg = wr_en && addr == 3'd0;
  wire w_hs  = wr_en && addr == 3'd1;
  wire w_vs  = wr_en && addr == 3'd2;
  wire w_tot = wr_en && addr == 3'd3;
  wire w_ha  = wr_en && addr == 3'd4;
  wire w_va  = wr_en && addr == 3'd5;
  wire w_ctl = wr_en && addr == 3'd6;
  wire w_st  = wr_en && addr == 3'd7;

  wire h_last = hcnt == h_tot - 1'b1;
  wire v_last = vcnt == v_tot - 1'b1;
  wire fend   = running && h_last && v_last;
  wire stop   = fend && ctl[1];
  wire go     = w_ctl && wdata[3] && !wdata[4] && !running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; hs_end <= '0; vs_end <= '0; h_tot <= '0; v_tot <= '0;
      h_beg <= '0; h_fin <= '0; v_beg <= '0; v_fin <= '0;
    end else begin
      if (w_cfg) cfg <= wdata[11:8];
      if (w_hs)  hs_end <= wdata[CW-1:0];
      if (w_vs)  vs_end <= wdata[CW-1:0];
      if (w_tot) begin h_tot <= wdata[HI +: CW]; v_tot <= wdata[CW-1:0]; end
      if (w_ha)  begin h_beg <= wdata[HI +: CW]; h_fin <= wdata[CW-1:0]; end
      if (w_va)  begin v_beg <= wdata[HI +: CW]; v_fin <= wdata[CW-1:0]; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (w_ctl) begin
      ctl <= {wdata[13], wdata[4], wdata[3]};
    end else if (stop) begin
      ctl[1:0] <= 2'b00;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      hcnt    <= '0;
      vcnt    <= '0;
    end else begin
      if (go) running <= 1'b1;
      else if (stop) running <= 1'b0;
      if (!running || stop) begin
        hcnt <= '0;
        vcnt <= '0;
      end else if (h_last) begin
        hcnt <= '0;
        vcnt <= v_last ? '0 : vcnt + 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_eof <= 1'b0;
      st_dis <= 1'b0;
    end else begin
      st_eof <= fend ? 1'b1 : (w_st ? wdata[5] : st_eof);
      st_dis <= stop ? 1'b1 : (w_st ? wdata[0] : st_dis);
    end
  end

  wire h_in   = hcnt >= h_beg && hcnt < h_fin;
  wire v_in   = vcnt >= v_beg && vcnt < v_fin;
  wire de_raw = running && h_in && v_in;
  wire hs_raw = running && hcnt < hs_end;
  wire vs_raw = running && vcnt < vs_end;

  assign hsync     = hs_raw ^ cfg[3];
  assign vsync     = vs_raw ^ cfg[0];
  assign de        = de_raw ^ cfg[1];
  assign pix_clk_o = clk ^ cfg[2];
  assign pix_x     = de_raw ? hcnt - h_beg : '0;
  assign pix_y     = de_raw ? vcnt - v_beg : '0;
  assign irq       = st_eof & ctl[2];

  always_comb begin
    rd_data = '0;
    case (addr)
      3'd0: rd_data[11:8] = cfg;
      3'd1: rd_data[CW-1:0] = hs_end;
      3'd2: rd_data[CW-1:0] = vs_end;
      3'd3: begin rd_data[HI +: CW] = h_tot; rd_data[CW-1:0] = v_tot; end
      3'd4: begin rd_data[HI +: CW] = h_beg; rd_data[CW-1:0] = h_fin; end
      3'd5: begin rd_data[HI +: CW] = v_beg; rd_data[CW-1:0] = v_fin; end
      3'd6: begin rd_data[13] = ctl[2]; rd_data[4] = ctl[1]; rd_data[3] = ctl[0]; end
      default: begin rd_data[5] = st_eof; rd_data[0] = st_dis; end
    endcase
  end

  // R2: the horizontal count returns to zero after the last pixel of a line
  a_r2_hwrap: assert property (@(posedge clk) disable iff (!rst_n)
    (running && h_last) |=> (hcnt == '0));

  // R6: the raster only stops right after a frame's last pixel
  a_r6_stop_at_eof: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(fend));

  // R6: stopping always leaves the disabled flag set
  a_r6_dis_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> st_dis);

  // R7: the end-of-frame flag is set after every frame end
  a_r7_eof_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fend |=> st_eof);

  // R6: while stopped, the counters hold at zero
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !$past(running)) |-> (hcnt == '0 && vcnt == '0));
endmodule

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;
  localparam int CW  = 10;
  localparam int HT  = 12, HSE = 2, HB = 4, HE = 10;
  localparam int VT  = 6,  VSE = 1, VB = 2, VE = 5;
  localparam int IW  = 3 + 2*CW;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rd_data;
  logic hsync, vsync, de, pix_clk_o, irq;
  logic [CW-1:0] pix_x, pix_y;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [IW-1:0] q[$];

  always #2.5 clk = ~clk;

  lcd_timing_gen #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .hsync(hsync), .vsync(vsync), .de(de),
    .pix_x(pix_x), .pix_y(pix_y), .pix_clk_o(pix_clk_o), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #0.5 d = rd_data;
  endtask

  task automatic push_frame(input logic [3:0] pol);
    for (int v = 0; v < VT; v++)
      for (int h = 0; h < HT; h++) begin
        logic act;
        logic [CW-1:0] x, y;
        act = (h >= HB) && (h < HE) && (v >= VB) && (v < VE);
        x = act ? CW'(h - HB) : '0;
        y = act ? CW'(v - VB) : '0;
        q.push_back({logic'(h < HSE) ^ pol[3], logic'(v < VSE) ^ pol[0], act ^ pol[1], x, y});
      end
  endtask

  task automatic push_idle(input logic [3:0] pol, input int n);
    for (int i = 0; i < n; i++) q.push_back({pol[3], pol[0], pol[1], {CW{1'b0}}, {CW{1'b0}}});
  endtask

  // starts the raster and queues one frame then idle cycles (R6)
  task automatic start_run(input logic [3:0] pol);
    @(negedge clk); addr = 3'd6; wdata = 32'h8; wr_en = 1'b1;
    push_frame(pol);
    push_idle(pol, 4);
    @(negedge clk); wr_en = 1'b0;
  endtask

  // scoreboard monitor: R2 R3 R4 R5
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      logic [IW-1:0] e, a;
      e = q.pop_front();
      a = {hsync, vsync, de, pix_x, pix_y};
      chk(a == e, "R2/R3/R4/R5 raster", 32'(a), 32'(e));
    end
  end

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({hsync, vsync, de, irq} == 4'b0, "R1 outputs", {hsync, vsync, de, irq}, 0);
    rd(3'd7, d); chk(d == 0, "R1 status", d, 0);

    wr(3'd1, HSE);
    wr(3'd2, VSE);
    wr(3'd3, (HT << 16) | VT);
    wr(3'd4, (HB << 16) | HE);
    wr(3'd5, (VB << 16) | VE);
    rd(3'd3, d); chk(d == ((HT << 16) | VT), "R9 totals", d, (HT << 16) | VT);
    rd(3'd4, d); chk(d == ((HB << 16) | HE), "R9 h active", d, (HB << 16) | HE);
    rd(3'd5, d); chk(d == ((VB << 16) | VE), "R9 v active", d, (VB << 16) | VE);
    rd(3'd1, d); chk(d == HSE, "R9 hsync end", d, HSE);

    start_run(4'b0000);
    repeat (20) @(negedge clk);
    wr(3'd6, 32'h2010);
    wait (q.size() == 0);
    rd(3'd7, d); chk(d == 32'h21, "R6/R7 status after stop", d, 32'h21);
    chk(irq == 1'b1, "R8 irq enabled", irq, 1);
    repeat (5) @(negedge clk);
    chk({hsync, vsync, de} == 3'b0, "R6 held idle", {hsync, vsync, de}, 0);
    wr(3'd7, 0);
    rd(3'd7, d); chk(d == 0, "R7 status cleared", d, 0);
    chk(irq == 1'b0, "R8 irq after clear", irq, 0);

    wr(3'd0, 32'hF00);
    rd(3'd0, d); chk(d == 32'hF00, "R9 config", d, 32'hF00);
    chk({hsync, vsync, de} == 3'b111, "R5 idle inverted", {hsync, vsync, de}, 3'b111);
    @(posedge clk); #0.5;
    chk(pix_clk_o == 1'b0, "R5 pixel clock inverted", pix_clk_o, 0);
    start_run(4'b1011);
    repeat (30) @(negedge clk);
    wr(3'd6, 32'h10);
    wait (q.size() == 0);
    rd(3'd7, d); chk(d == 32'h21, "R7 eof again", d, 32'h21);
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    wr(3'd0, 0);
    @(posedge clk); #0.5;
    chk(pix_clk_o == 1'b1, "R5 pixel clock true", pix_clk_o, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule